// File: doc/BRIEF.md
# PHY Register Auto-Poll Monitor

This block watches up to six registers inside an external Ethernet PHY without software polling. Each of six slots holds a PHY register address and an enable bit. A sequencer visits the enabled slots in turn. For each visit it asks a management-interface controller to read that register, using a request/grant/done handshake. It then compares the returned word with the value kept for that slot. When the word differs, a one-cycle pulse appears on the interrupt bit that belongs to that slot. The serial management protocol itself lives in the controller on the far side of the handshake.

One slot also carries the link indication. A selectable bit of the word read through slot 0 is treated as link status, and a change of that bit raises a separate link-change pulse. The pulses are meant to drive the set inputs of a wider interrupt status register, so they come out already placed at their final bit positions in a 32-bit vector.

Top module: `phy_autopoll_mon`

## Requirements
- R1: After reset every slot is disabled and holds no value. `mgmt_req` is 0 and `irq_pulse` is all zero.
- R2: Enabled slots are read in ascending slot order, wrapping from the highest enabled slot to the lowest. Only one read is outstanding at a time. `mgmt_req` stays high until a cycle with `mgmt_gnt` high and then drops. No new request is made until `mgmt_done` has returned.
- R3: A read that completes without error on a slot that already holds a value is compared with that value. If the two differ, the slot's interrupt bit in `irq_pulse` is high for exactly the one cycle after the `mgmt_done` cycle, and the new word is stored. If they are equal, no pulse is raised.
- R4: Slot interrupt bits are at these positions: slot 0 at bit 20, slot 1 at bit 21, slot 2 at bit 22, slot 3 at bit 24, slot 4 at bit 25 and slot 5 at bit 26. Bit 23 and every bit outside 20 to 27 are never set.
- R5: When a compared read of slot 0 changes the bit selected by `link_sel`, bit 27 of `irq_pulse` pulses in the same cycle as bit 20.
- R6: A configuration write (`cfg_we` high) to a slot discards that slot's stored value. This includes a read of that slot already in flight. The first read completed after the write only stores the word and raises no pulse.
- R7: A read that completes with `mgmt_err` high raises no pulse and leaves the stored value unchanged.
- R8: A slot whose enable bit is 0 is never read. When all slots are disabled, `mgmt_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one slot's configuration |
| cfg_slot | input | 3 | Slot index written (0 to 5) |
| cfg_addr | input | 5 | PHY register address for the slot |
| cfg_en | input | 1 | Enable bit for the slot |
| link_sel | input | 4 | Bit index of link status within slot 0's word |
| mgmt_req | output | 1 | Read request to the management controller |
| mgmt_addr | output | 5 | PHY register address of the request |
| mgmt_gnt | input | 1 | Controller accepted the request |
| mgmt_done | input | 1 | Read finished; data and error valid this cycle |
| mgmt_err | input | 1 | Finished read is invalid |
| mgmt_rdata | input | 16 | Word read from the PHY |
| irq_pulse | output | 32 | One-cycle interrupt set pulses at bits 20 to 22 and 24 to 27 |

## Verification
The monitor is driven with a sequence of PHY register updates, one slot at a time, that mixes three kinds of change: a changed word that also flips the link bit, a changed word with the link bit held, and a word rewritten with the same value. This separates a per-slot change from a link change and from no change, and it confirms that each slot reaches its own bit, including the jump over bit 23. The directed cases cover the following:
- An error read followed by a clean read, which shows that the stored value was not overwritten.
- A reconfiguration during an in-flight read.
- A logged read order with one slot disabled.
- A fully disabled bank.

// File: rtl/apm_pkg.sv
package apm_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REQ  = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_e;

    localparam int LINK_IRQ_BIT = 27;

    // slot interrupt placement: three low slots, one gap, three high slots
    function automatic int slot_irq_bit(input int slot);
        return (slot < 3) ? (20 + slot) : (21 + slot);
    endfunction

    function automatic logic [31:0] irq_allowed_mask(input int num_slots);
        logic [31:0] m;
        m = 32'(1) << LINK_IRQ_BIT;
        for (int i = 0; i < num_slots; i++) begin
            m = m | (32'(1) << slot_irq_bit(i));
        end
        return m;
    endfunction

endpackage

// File: rtl/apm_slot_bank.sv
module apm_slot_bank #(
    parameter int NUM_SLOTS = 6,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [SLOT_W-1:0]                  cfg_slot,
    input  logic [ADDR_W-1:0]                  cfg_addr,
    input  logic                               cfg_en,
    input  logic                               upd_we,
    input  logic [SLOT_W-1:0]                  upd_slot,
    input  logic [DATA_W-1:0]                  upd_data,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0]   slot_addr,
    output logic [NUM_SLOTS-1:0]               slot_en,
    output logic [NUM_SLOTS-1:0]               slot_valid,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]   slot_val
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0][ADDR_W-1:0] addr;
        logic [NUM_SLOTS-1:0]             en;
        logic [NUM_SLOTS-1:0]             valid;
        logic [NUM_SLOTS-1:0][DATA_W-1:0] val;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (upd_we && (upd_slot == SLOT_W'(i))) begin
                bank_d.val[i]   = upd_data;
                bank_d.valid[i] = 1'b1;
            end
            // configuration takes priority and forgets the stored word
            if (cfg_we && (cfg_slot == SLOT_W'(i))) begin
                bank_d.addr[i]  = cfg_addr;
                bank_d.en[i]    = cfg_en;
                bank_d.valid[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign slot_addr  = bank_q.addr;
    assign slot_en    = bank_q.en;
    assign slot_valid = bank_q.valid;
    assign slot_val   = bank_q.val;

endmodule

// File: rtl/apm_rr_pick.sv
module apm_rr_pick #(
    parameter int NUM_SLOTS = 6,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] en,
    input  logic [SLOT_W-1:0]    last,
    output logic                 found,
    output logic [SLOT_W-1:0]    pick
);

    always_comb begin
        found = 1'b0;
        pick  = last;
        for (int k = 1; k <= NUM_SLOTS; k++) begin
            int idx;
            idx = (int'(last) + k) % NUM_SLOTS;
            if (!found && en[idx]) begin
                found = 1'b1;
                pick  = SLOT_W'(idx);
            end
        end
    end

endmodule

// File: rtl/apm_change_detect.sv
module apm_change_detect #(
    parameter int DATA_W  = 16,
    localparam int LSEL_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] stored,
    input  logic              stored_valid,
    input  logic              is_link_slot,
    input  logic [LSEL_W-1:0] link_sel,
    output logic              changed,
    output logic              link_changed
);

    always_comb begin
        changed      = stored_valid && (rdata != stored);
        link_changed = stored_valid && is_link_slot &&
                       (rdata[link_sel] != stored[link_sel]);
    end

endmodule

// File: rtl/phy_autopoll_mon.sv
module phy_autopoll_mon #(
    parameter int NUM_SLOTS = 6,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int IRQ_W     = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int LSEL_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_en,
    input  logic [LSEL_W-1:0] link_sel,
    output logic              mgmt_req,
    output logic [ADDR_W-1:0] mgmt_addr,
    input  logic              mgmt_gnt,
    input  logic              mgmt_done,
    input  logic              mgmt_err,
    input  logic [DATA_W-1:0] mgmt_rdata,
    output logic [IRQ_W-1:0]  irq_pulse
);

    import apm_pkg::*;

    typedef struct packed {
        seq_state_e        st;
        logic [SLOT_W-1:0] cur;
        logic              cancel;
        logic [IRQ_W-1:0]  irq;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
    logic [NUM_SLOTS-1:0]             slot_en;
    logic [NUM_SLOTS-1:0]             slot_valid;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_val;
    logic [NUM_SLOTS-1:0][IRQ_W-1:0]  slot_irq_mask;

    logic              pick_found;
    logic [SLOT_W-1:0] pick_slot;
    logic              changed, link_changed;
    logic              upd_we;
    logic              cfg_hit;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_irq_map
        assign slot_irq_mask[g] = IRQ_W'(1) << slot_irq_bit(g);
    end

    apm_slot_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_slot   (cfg_slot),
        .cfg_addr   (cfg_addr),
        .cfg_en     (cfg_en),
        .upd_we     (upd_we),
        .upd_slot   (seq_q.cur),
        .upd_data   (mgmt_rdata),
        .slot_addr  (slot_addr),
        .slot_en    (slot_en),
        .slot_valid (slot_valid),
        .slot_val   (slot_val)
    );

    apm_rr_pick #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_pick (
        .en    (slot_en),
        .last  (seq_q.cur),
        .found (pick_found),
        .pick  (pick_slot)
    );

    apm_change_detect #(
        .DATA_W (DATA_W)
    ) u_cmp (
        .rdata        (mgmt_rdata),
        .stored       (slot_val[seq_q.cur]),
        .stored_valid (slot_valid[seq_q.cur]),
        .is_link_slot (seq_q.cur == '0),
        .link_sel     (link_sel),
        .changed      (changed),
        .link_changed (link_changed)
    );

    always_comb begin
        seq_d     = seq_q;
        seq_d.irq = '0;
        upd_we    = 1'b0;
        cfg_hit   = cfg_we && (cfg_slot == seq_q.cur);
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (pick_found) begin
                    seq_d.cur    = pick_slot;
                    seq_d.cancel = 1'b0;
                    seq_d.st     = SEQ_REQ;
                end
            end
            SEQ_REQ: begin
                seq_d.cancel = seq_q.cancel | cfg_hit;
                if (mgmt_gnt) begin
                    seq_d.st = SEQ_WAIT;
                end
            end
            SEQ_WAIT: begin
                seq_d.cancel = seq_q.cancel | cfg_hit;
                if (mgmt_done) begin
                    seq_d.st     = SEQ_IDLE;
                    seq_d.cancel = 1'b0;
                    if (!mgmt_err && !seq_q.cancel && !cfg_hit) begin
                        upd_we = 1'b1;
                        if (changed) begin
                            seq_d.irq = seq_d.irq | slot_irq_mask[seq_q.cur];
                        end
                        if (link_changed) begin
                            seq_d.irq[LINK_IRQ_BIT] = 1'b1;
                        end
                    end
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st     <= SEQ_IDLE;
            seq_q.cur    <= SLOT_W'(NUM_SLOTS - 1);
            seq_q.cancel <= 1'b0;
            seq_q.irq    <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mgmt_req  = (seq_q.st == SEQ_REQ);
    assign mgmt_addr = slot_addr[seq_q.cur];
    assign irq_pulse = seq_q.irq;

endmodule

// File: rtl/apm_checker.sv
module apm_checker #(
    parameter int NUM_SLOTS = 6,
    parameter int IRQ_W     = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mgmt_req,
    input logic                 mgmt_gnt,
    input logic                 mgmt_done,
    input logic                 mgmt_err,
    input logic [IRQ_W-1:0]     irq_pulse,
    input logic [NUM_SLOTS-1:0] slot_en
);

    import apm_pkg::*;

    localparam logic [IRQ_W-1:0] ALLOWED = IRQ_W'(irq_allowed_mask(NUM_SLOTS));
    localparam int SLOT0_BIT = slot_irq_bit(0);

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_req && !mgmt_gnt |=> mgmt_req);

    assert_req_drop_on_gnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_req && mgmt_gnt |=> !mgmt_req);

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_pulse) |=> (irq_pulse == '0));

    assert_pulse_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_pulse) |-> $past(mgmt_done));

    assert_no_reserved_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse & ~ALLOWED) == '0);

    assert_link_with_slot0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse[LINK_IRQ_BIT] |-> irq_pulse[SLOT0_BIT]);

    assert_err_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_done && mgmt_err |=> (irq_pulse == '0));

    assert_idle_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en == '0) && !mgmt_req |=> !mgmt_req);

endmodule

bind phy_autopoll_mon apm_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .IRQ_W     (IRQ_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mgmt_req  (mgmt_req),
    .mgmt_gnt  (mgmt_gnt),
    .mgmt_done (mgmt_done),
    .mgmt_err  (mgmt_err),
    .irq_pulse (irq_pulse),
    .slot_en   (slot_en)
);

// File: tb/phy_autopoll_mon_tb.sv
`timescale 1ns/1ps
module phy_autopoll_mon_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_slot;
    logic [4:0]  cfg_addr;
    logic        cfg_en;
    logic [3:0]  link_sel;
    logic        mgmt_req;
    logic [4:0]  mgmt_addr;
    logic        mgmt_gnt;
    logic        mgmt_done;
    logic        mgmt_err;
    logic [15:0] mgmt_rdata;
    logic [31:0] irq_pulse;

    always #2.5 clk = ~clk;

    phy_autopoll_mon u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_slot   (cfg_slot),
        .cfg_addr   (cfg_addr),
        .cfg_en     (cfg_en),
        .link_sel   (link_sel),
        .mgmt_req   (mgmt_req),
        .mgmt_addr  (mgmt_addr),
        .mgmt_gnt   (mgmt_gnt),
        .mgmt_done  (mgmt_done),
        .mgmt_err   (mgmt_err),
        .mgmt_rdata (mgmt_rdata),
        .irq_pulse  (irq_pulse)
    );

    localparam logic [4:0] SA [6] = '{5'd1, 5'd4, 5'd5, 5'd16, 5'd17, 5'd30};

    // {slot, new PHY word}
    localparam logic [18:0] VEC [10] = '{
        {3'd0, 16'h1009}, {3'd0, 16'h1109}, {3'd0, 16'h1109}, {3'd3, 16'hABCD},
        {3'd1, 16'h0000}, {3'd5, 16'h101E}, {3'd5, 16'hFFFF}, {3'd4, 16'h2011},
        {3'd2, 16'h1005}, {3'd0, 16'h1101}
    };

    int checks = 0;
    int failures = 0;

    logic [15:0] phy_mem [32];
    int          rd_cnt  [32];
    logic [4:0]  order_log [64];
    int          log_n = 0;
    logic        busy = 1'b0;
    logic [4:0]  cur_a = '0;
    int          lat = 0;
    logic        err_on = 1'b0;
    logic [4:0]  err_addr = '0;
    logic [31:0] sticky = '0;
    logic [31:0] sticky_all = '0;

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int bitpos(input int s);
        return (s < 3) ? 20 + s : 21 + s;
    endfunction

    function automatic logic [31:0] exp_mask(input int s, input logic [15:0] oldv,
                                             input logic [15:0] newv, input int sel);
        logic [31:0] m;
        m = '0;
        if (oldv != newv) begin
            m[bitpos(s)] = 1'b1;
            if (s == 0 && oldv[sel] != newv[sel]) m[27] = 1'b1;
        end
        return m;
    endfunction

    function automatic int slot_of(input logic [4:0] a);
        for (int i = 0; i < 6; i++) if (SA[i] == a) return i;
        return -1;
    endfunction

    // management controller model
    initial begin
        mgmt_gnt = 1'b0; mgmt_done = 1'b0; mgmt_err = 1'b0; mgmt_rdata = '0;
        for (int i = 0; i < 32; i++) begin
            phy_mem[i] = 16'h1000 + 16'(i);
            rd_cnt[i] = 0;
        end
        forever begin
            @(negedge clk);
            mgmt_gnt = 1'b0;
            mgmt_done = 1'b0;
            mgmt_err = 1'b0;
            if (busy) begin
                if (lat == 0) begin
                    mgmt_done  = 1'b1;
                    mgmt_rdata = phy_mem[cur_a];
                    mgmt_err   = err_on && (cur_a == err_addr);
                    busy = 1'b0;
                    rd_cnt[cur_a] = rd_cnt[cur_a] + 1;
                    if (log_n < 64) order_log[log_n] = cur_a;
                    log_n++;
                end else begin
                    lat--;
                end
            end else if (mgmt_req && rst_n) begin
                mgmt_gnt = 1'b1;
                cur_a = mgmt_addr;
                busy = 1'b1;
                lat = 2;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            sticky = sticky | irq_pulse;
            sticky_all = sticky_all | irq_pulse;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic cfg_write(input int s, input logic [4:0] a, input logic en);
        cfg_we = 1'b1; cfg_slot = 3'(s); cfg_addr = a; cfg_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_read(input logic [4:0] a);
        int start;
        start = rd_cnt[a];
        while (rd_cnt[a] == start) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_order(input logic [5:0] en_mask, input string tag);
        int bad;
        bad = 0;
        log_n = 0;
        while (log_n < 13) @(negedge clk);
        for (int i = 1; i < 13; i++) begin
            int s, n;
            s = slot_of(order_log[i-1]);
            n = s;
            for (int k = 1; k <= 6; k++) begin
                if (en_mask[(s + k) % 6]) begin n = (s + k) % 6; break; end
            end
            if (order_log[i] != SA[n] || !en_mask[slot_of(order_log[i])]) bad++;
        end
        check(bad == 0, tag, 32'(bad), 32'd0);
    endtask

    task automatic apply(input int s, input logic [15:0] v, input string tag);
        logic [15:0] oldv;
        logic [31:0] exp;
        oldv = phy_mem[SA[s]];
        exp = exp_mask(s, oldv, v, int'(link_sel));
        sticky = '0;
        phy_mem[SA[s]] = v;
        wait_read(SA[s]);
        check(sticky == exp, tag, sticky, exp);
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_slot = '0; cfg_addr = '0; cfg_en = 1'b0;
        link_sel = 4'd3;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R8: reset state, nothing enabled, no requests
        begin
            int reqs;
            reqs = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (mgmt_req) reqs++;
            end
            check(reqs == 0, "R1 no request after reset (R8 all disabled)", 32'(reqs), 32'd0);
            check(irq_pulse == '0 && sticky == '0, "R1 irq_pulse zero after reset", sticky, 32'd0);
        end

        // R6: enabling all slots: first reads load only
        for (int s = 0; s < 6; s++) cfg_write(s, SA[s], 1'b1);
        sticky = '0;
        wait_read(SA[5]);
        wait_read(SA[5]);
        check(sticky == '0, "R6 first reads after enable raise nothing", sticky, 32'd0);

        // R2: round-robin order over all slots
        check_order(6'b111111, "R2 round-robin order all enabled");

        // R3 R4 R5: vector table
        for (int i = 0; i < 10; i++) begin
            apply(int'(VEC[i][18:16]), VEC[i][15:0], "R3/R4/R5 vector change pulse");
        end

        // R7: error read discarded, stored value kept
        sticky = '0;
        err_addr = SA[2]; err_on = 1'b1;
        phy_mem[SA[2]] = 16'h5A5A;
        wait_read(SA[2]);
        check(sticky == '0, "R7 error read raises no pulse", sticky, 32'd0);
        err_on = 1'b0;
        sticky = '0;
        wait_read(SA[2]);
        check(sticky == (32'd1 << 22), "R7 stored value unchanged by error read",
              sticky, 32'd1 << 22);

        // R6: reconfiguration during an in-flight read
        begin
            int start;
            start = rd_cnt[SA[1]];
            while (rd_cnt[SA[1]] == start) @(negedge clk);
            phy_mem[SA[1]] = 16'h7777;
            sticky = '0;
            while (!(busy && cur_a == SA[1])) @(negedge clk);
            cfg_write(1, SA[1], 1'b1);
            wait_read(SA[1]);
            wait_read(SA[1]);
            check(sticky == '0, "R6 in-flight read discarded on reconfig", sticky, 32'd0);
            apply(1, 16'h7778, "R6 slot live again after reconfig");
        end

        // R8: disabled slot skipped
        cfg_write(4, SA[4], 1'b0);
        begin
            int start;
            start = rd_cnt[SA[4]];
            sticky = '0;
            phy_mem[SA[4]] = 16'h4444;
            check_order(6'b101111, "R8 disabled slot skipped in order");
            check(rd_cnt[SA[4]] == start && sticky[25] == 1'b0,
                  "R8 disabled slot not read", 32'(rd_cnt[SA[4]] - start), 32'd0);
        end

        // R6: re-enable with a different word, no event; then change pulses bit 25 (R4)
        cfg_write(4, SA[4], 1'b1);
        sticky = '0;
        wait_read(SA[4]);
        check(sticky == '0, "R6 re-enable loads without event", sticky, 32'd0);
        apply(4, 16'h4445, "R4 slot 4 maps to bit 25");

        // R5: different link bit index
        link_sel = 4'd9;
        apply(0, phy_mem[SA[0]] ^ 16'h0200, "R5 link bit 9 toggled");
        apply(0, phy_mem[SA[0]] ^ 16'h0008, "R5 bit 3 not link when index 9");

        // R8: all disabled -> idle
        for (int s = 0; s < 6; s++) cfg_write(s, SA[s], 1'b0);
        repeat (8) @(negedge clk);
        begin
            int reqs;
            reqs = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (mgmt_req) reqs++;
            end
            check(reqs == 0, "R8 no request with all slots disabled", 32'(reqs), 32'd0);
        end

        // R4: no reserved bit ever seen
        check((sticky_all & ~32'h0F70_0000) == '0, "R4 no bit outside 20-22,24-27",
              sticky_all, sticky_all & 32'h0F70_0000);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule